// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block is one DMA channel. It copies data items between a peripheral data register and memory over a simple bus that has a single master. Software sets up the channel through plain configuration inputs. These give a start address for each side, an item count, a data size and an increment enable for each side, the copy direction, circular operation, and one interrupt enable for each event flag.

A peripheral asks for each item with a four-phase request/acknowledge handshake. For each item the channel requests the bus and waits for the grant. It then reads one item from the source, writes it to the destination, and releases the bus, so other traffic can use the bus between items. Three sticky flags record events: half of the items moved, all items moved, and an external abort. These flags drive a single interrupt line through their enables.

When the two sides use different sizes, no packing is done. A narrower source value is zero-extended, and a wider one is cut to its low bits.

Top module: `pdma_channel`

## Requirements
- R1: A transfer run starts only on a rising edge of `cfg_en` with a nonzero `cfg_count`. That edge loads both start addresses, and the first item uses those addresses unchanged. A zero count, or a request while `cfg_en` is low, produces no acknowledge, no bus request and no flags.
- R2: `periph_ack` rises only after the item's destination write has been accepted. It stays high until `periph_req` falls, and then it falls. Each request moves exactly one item.
- R3: `bus_req` is high from the item's request until its write is accepted. `bus_valid` is asserted only while `bus_gnt` is high, so no access starts before the grant. Each grant carries one read and then one write.
- R4: A bus access holds `bus_valid`, `bus_addr` and `bus_we` steady until `bus_ready`, and only one access is outstanding at a time.
- R5: With `cfg_dir`=0 the item is read at the peripheral pointer and written at the memory pointer. With `cfg_dir`=1 the two are swapped.
- R6: Each side's pointer advances after every item only if that side's increment enable is set. The step is 1, 2 or 4 bytes for size codes 0, 1 and 2 (code 3 acts as 4). A side whose increment is off stays at its start address.
- R7: Read data is right-justified on `bus_rdata`/`bus_wdata`, and bytes are little-endian in memory. The item read is masked to the source size. The value written is that item masked to the destination size, and `bus_size` carries the size code of the side being accessed.
- R8: After `cfg_count` items the done flag (bit 1) is set. In non-circular mode the channel then stops and leaves further requests unacknowledged.
- R9: The half flag (bit 0) is set when the remaining count becomes floor(`cfg_count`/2).
- R10: In circular mode, reaching zero reloads both start addresses and the count. Service continues with no new enable edge, and the flags are raised again on each pass.
- R11: A high `abort_evt` during a run stops the channel at once. It drops any acknowledge or bus request, sets the abort flag (bit 2), and leaves later requests unserved until a new enable edge.
- R12: Flags stay set until the matching bit of `flag_clr` is pulsed. `irq` is the OR of the flags that `cfg_irq_en` enables (same bit order).
- R13: Dropping `cfg_en` stops the channel and clears its count. The next rising edge restarts at the start addresses with the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Channel enable; rising edge starts a run |
| cfg_dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_circ | input | 1 | Circular reload mode |
| cfg_psize | input | 2 | Peripheral size code (0:8, 1:16, 2/3:32 bits) |
| cfg_msize | input | 2 | Memory size code |
| cfg_pinc | input | 1 | Peripheral pointer increment enable |
| cfg_minc | input | 1 | Memory pointer increment enable |
| cfg_irq_en | input | 3 | Interrupt enables {abort, done, half} |
| cfg_paddr | input | AW | Peripheral start address |
| cfg_maddr | input | AW | Memory start address |
| cfg_count | input | CW | Items per run |
| flag_clr | input | 3 | Write-one clear pulses for the flags |
| flags | output | 3 | Sticky flags {abort, done, half} |
| irq | output | 1 | Interrupt line |
| abort_evt | input | 1 | External abort event |
| periph_req | input | 1 | Peripheral item request |
| periph_ack | output | 1 | Item acknowledge |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Access valid |
| bus_ready | input | 1 | Access accepted / read data valid |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Byte address |
| bus_size | output | 2 | Size code of this access |
| bus_wdata | output | 32 | Right-justified write data |
| bus_rdata | input | 32 | Right-justified read data |

## Verification
The embedded assertions watch several rules on every cycle. These are the handshake order (acknowledge only after an accepted write, and held while the request stays high), the bus rules (no valid without a grant, access fields frozen while stalled), the flags staying sticky, the counter never decrementing past zero, and the pointers holding when they are not told to step. Data values cannot be checked that way: the zero-extension and truncation between sizes, which pointer feeds which side, the point where the half flag fires, circular reload, and restart after disable or abort. Only the bench's scenarios show these, by comparing memory contents and flags against values computed from the requirements, across every size, increment and direction combination.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

   localparam int unsigned DATA_W = 32;
   localparam int unsigned NFLAGS = 3;
   localparam int unsigned FLG_HALF  = 0;
   localparam int unsigned FLG_DONE  = 1;
   localparam int unsigned FLG_ABORT = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GNT,
      ST_RD,
      ST_WR,
      ST_ACK
   } chan_state_e;

   // byte step for a size code
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    size_bytes = 3'd1;
         2'd1:    size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

   // low-bit mask for a size code
   function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] code);
      case (code)
         2'd0:    size_mask = DATA_W'(32'h0000_00FF);
         2'd1:    size_mask = DATA_W'(32'h0000_FFFF);
         default: size_mask = DATA_W'(32'hFFFF_FFFF);
      endcase
   endfunction

endpackage

// File: rtl/pdma_ptr.sv
module pdma_ptr
   import pdma_pkg::*;
#(
   parameter int unsigned AW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          inc,
   input  logic [1:0]    size,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] addr
);

   generate
      if (AW < 8) begin : g_aw_chk
         $error("pdma_ptr: AW must be at least 8");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= base;
      end else if (step && inc) begin
         addr <= addr + AW'(size_bytes(size));
      end
   end

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(step && inc)) |=> $stable(addr)); // R6

endmodule

// File: rtl/pdma_count.sv
module pdma_count #(
   parameter int unsigned CW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          clear,
   input  logic          dec,
   input  logic [CW-1:0] total,
   output logic          half_hit,
   output logic          last_hit
);

   generate
      if (CW < 2) begin : g_cw_chk
         $error("pdma_count: CW must be at least 2");
      end
   endgenerate

   logic [CW-1:0] remaining;
   logic [CW-1:0] half_mark;
   logic [CW-1:0] rem_next;

   assign rem_next = remaining - CW'(1);
   assign half_hit = dec && (rem_next == half_mark);
   assign last_hit = dec && (rem_next == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remaining <= '0;
         half_mark <= '0;
      end else if (load) begin
         remaining <= total;
         half_mark <= total >> 1;
      end else if (clear) begin
         remaining <= '0;
      end else if (dec) begin
         remaining <= rem_next;
      end
   end

   AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (remaining != '0)); // R8

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
   import pdma_pkg::*;
#(
   parameter int unsigned AW           = 32,
   parameter int unsigned CW           = 16,
   parameter bit          CIRC_SUPPORT = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_en,
   input  logic               cfg_dir,
   input  logic               cfg_circ,
   input  logic [1:0]         cfg_psize,
   input  logic [1:0]         cfg_msize,
   input  logic               cfg_pinc,
   input  logic               cfg_minc,
   input  logic [NFLAGS-1:0]  cfg_irq_en,
   input  logic [AW-1:0]      cfg_paddr,
   input  logic [AW-1:0]      cfg_maddr,
   input  logic [CW-1:0]      cfg_count,
   input  logic [NFLAGS-1:0]  flag_clr,
   output logic [NFLAGS-1:0]  flags,
   output logic               irq,
   input  logic               abort_evt,
   input  logic               periph_req,
   output logic               periph_ack,
   output logic               bus_req,
   input  logic               bus_gnt,
   output logic               bus_valid,
   input  logic               bus_ready,
   output logic               bus_we,
   output logic [AW-1:0]      bus_addr,
   output logic [1:0]         bus_size,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic [DATA_W-1:0]  bus_rdata
);

   localparam int unsigned NSIDES = 2;   // 0: peripheral, 1: memory

   generate
      if (AW < 8) begin : g_aw_chk
         $error("pdma_channel: AW must be at least 8");
      end
      if (CW < 2) begin : g_cw_chk
         $error("pdma_channel: CW must be at least 2");
      end
   endgenerate

   chan_state_e        state;
   logic               run;
   logic               en_q;
   logic [DATA_W-1:0]  data_q;
   logic [NFLAGS-1:0]  flags_q;
   logic               circ_on;

   generate
      if (CIRC_SUPPORT) begin : g_circ
         assign circ_on = cfg_circ;
      end else begin : g_nocirc
         logic unused_circ;
         assign unused_circ = cfg_circ;
         assign circ_on     = 1'b0;
      end
   endgenerate

   // run control terms
   logic start;
   logic stop_abort;
   logic step_ok;
   logic half_hit;
   logic last_hit;
   logic reload;

   assign start      = cfg_en && !en_q && (cfg_count != '0);
   assign stop_abort = abort_evt && run;
   assign step_ok    = (state == ST_WR) && bus_ready && cfg_en && !stop_abort;
   assign reload     = start || (last_hit && circ_on);

   // per-side pointer units
   logic [AW-1:0] side_base [NSIDES];
   logic [1:0]    side_size [NSIDES];
   logic          side_inc  [NSIDES];
   logic [AW-1:0] side_addr [NSIDES];

   assign side_base[0] = cfg_paddr;
   assign side_base[1] = cfg_maddr;
   assign side_size[0] = cfg_psize;
   assign side_size[1] = cfg_msize;
   assign side_inc[0]  = cfg_pinc;
   assign side_inc[1]  = cfg_minc;

   generate
      for (genvar g = 0; g < NSIDES; g++) begin : g_side
         pdma_ptr #(.AW(AW)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (reload),
            .step  (step_ok),
            .inc   (side_inc[g]),
            .size  (side_size[g]),
            .base  (side_base[g]),
            .addr  (side_addr[g])
         );
      end
   endgenerate

   pdma_count #(.CW(CW)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (reload),
      .clear    (!cfg_en),
      .dec      (step_ok),
      .total    (cfg_count),
      .half_hit (half_hit),
      .last_hit (last_hit)
   );

   // source / destination routing
   logic [AW-1:0] src_addr;
   logic [AW-1:0] dst_addr;
   logic [1:0]    src_size;
   logic [1:0]    dst_size;

   assign src_addr = side_addr[cfg_dir];
   assign dst_addr = side_addr[!cfg_dir];
   assign src_size = side_size[cfg_dir];
   assign dst_size = side_size[!cfg_dir];

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         run    <= 1'b0;
         en_q   <= 1'b0;
         data_q <= '0;
      end else begin
         en_q <= cfg_en;
         if (!cfg_en || stop_abort) begin
            state <= ST_IDLE;
            run   <= 1'b0;
         end else begin
            if (start) begin
               run <= 1'b1;
            end
            case (state)
               ST_IDLE: begin
                  if (run && periph_req) begin
                     state <= ST_GNT;
                  end
               end
               ST_GNT: begin
                  if (bus_gnt) begin
                     state <= ST_RD;
                  end
               end
               ST_RD: begin
                  if (bus_ready) begin
                     data_q <= bus_rdata & size_mask(src_size);
                     state  <= ST_WR;
                  end
               end
               ST_WR: begin
                  if (bus_ready) begin
                     state <= ST_ACK;
                     if (last_hit && !circ_on) begin
                        run <= 1'b0;
                     end
                  end
               end
               ST_ACK: begin
                  if (!periph_req) begin
                     state <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // sticky event flags
   logic [NFLAGS-1:0] flag_set;

   always_comb begin
      flag_set            = '0;
      flag_set[FLG_HALF]  = step_ok && half_hit;
      flag_set[FLG_DONE]  = step_ok && last_hit;
      flag_set[FLG_ABORT] = stop_abort;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else begin
         flags_q <= (flags_q & ~flag_clr) | flag_set;
      end
   end

   // outputs
   assign flags      = flags_q;
   assign irq        = |(flags_q & cfg_irq_en);
   assign periph_ack = (state == ST_ACK);
   assign bus_req    = (state == ST_GNT) || (state == ST_RD) || (state == ST_WR);
   assign bus_valid  = (state == ST_RD) || (state == ST_WR);
   assign bus_we     = (state == ST_WR);
   assign bus_addr   = (state == ST_WR) ? dst_addr : src_addr;
   assign bus_size   = (state == ST_WR) ? dst_size : src_size;
   assign bus_wdata  = data_q & size_mask(dst_size);

   // protocol checks
   AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(periph_ack) |-> $past(bus_valid && bus_ready && bus_we)); // R2

   AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n || abort_evt || !cfg_en)
      (periph_ack && periph_req) |=> periph_ack); // R2

   AST_VALID_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> bus_gnt); // R3

   AST_ACCESS_STABLE: assert property (@(posedge clk) disable iff (!rst_n || abort_evt || !cfg_en)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we))); // R4

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags & ~flag_clr)) |=>
         ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr))); // R12

   AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !bus_req); // R13

endmodule

// File: tb/pdma_channel_tb.sv
module pdma_channel_tb_top;

   localparam int AW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b0;
   logic          cfg_dir = 1'b0;
   logic          cfg_circ = 1'b0;
   logic [1:0]    cfg_psize = 2'd0;
   logic [1:0]    cfg_msize = 2'd0;
   logic          cfg_pinc = 1'b0;
   logic          cfg_minc = 1'b0;
   logic [2:0]    cfg_irq_en = 3'b000;
   logic [AW-1:0] cfg_paddr = '0;
   logic [AW-1:0] cfg_maddr = '0;
   logic [CW-1:0] cfg_count = '0;
   logic [2:0]    flag_clr = 3'b000;
   logic [2:0]    flags;
   logic          irq;
   logic          abort_evt = 1'b0;
   logic          periph_req = 1'b0;
   logic          periph_ack;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic          bus_valid;
   logic          bus_ready = 1'b0;
   logic          bus_we;
   logic [AW-1:0] bus_addr;
   logic [1:0]    bus_size;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata = '0;

   logic          other_busy = 1'b0;
   logic          bd_we = 1'b0;
   logic [7:0]    bd_addr = '0;
   logic [7:0]    bd_data = '0;
   logic [7:0]    mem [256];

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int r4_bad = 0;
   int r2_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   pdma_channel #(.AW(AW), .CW(CW)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_en     (cfg_en),
      .cfg_dir    (cfg_dir),
      .cfg_circ   (cfg_circ),
      .cfg_psize  (cfg_psize),
      .cfg_msize  (cfg_msize),
      .cfg_pinc   (cfg_pinc),
      .cfg_minc   (cfg_minc),
      .cfg_irq_en (cfg_irq_en),
      .cfg_paddr  (cfg_paddr),
      .cfg_maddr  (cfg_maddr),
      .cfg_count  (cfg_count),
      .flag_clr   (flag_clr),
      .flags      (flags),
      .irq        (irq),
      .abort_evt  (abort_evt),
      .periph_req (periph_req),
      .periph_ack (periph_ack),
      .bus_req    (bus_req),
      .bus_gnt    (bus_gnt),
      .bus_valid  (bus_valid),
      .bus_ready  (bus_ready),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_size   (bus_size),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata)
   );

   function automatic int nbytes(input logic [1:0] code);
      return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [7:0] pat(input int a);
      return 8'((a % 256) * 37 + 11);
   endfunction

   function automatic logic [31:0] pat_word(input int a, input int nb);
      logic [31:0] v = '0;
      for (int k = 0; k < nb; k++) v = v | (32'(pat(a + k)) << (8 * k));
      return v;
   endfunction

   function automatic logic [31:0] mem_word(input int a, input int nb);
      logic [31:0] v = '0;
      for (int k = 0; k < nb; k++) v = v | (32'(mem[8'(a + k)]) << (8 * k));
      return v;
   endfunction

   // arbiter and memory model: each access waits one cycle
   always @(posedge clk) begin
      bus_gnt   <= bus_req && !other_busy;
      bus_ready <= 1'b0;
      if (bd_we) begin
         mem[bd_addr] <= bd_data;
      end else if (bus_valid && !bus_ready) begin
         bus_ready <= 1'b1;
         if (bus_we) begin
            for (int k = 0; k < nbytes(bus_size); k++)
               mem[8'(bus_addr[7:0] + 8'(k))] <= 8'(bus_wdata >> (8 * k));
         end else begin
            bus_rdata <= mem_word(int'(bus_addr[7:0]), nbytes(bus_size));
         end
      end
   end

   // protocol monitors
   logic        pv = 1'b0;
   logic [31:0] pa = '0;
   logic        pw = 1'b0;
   logic        pab = 1'b0;
   logic        wr_seen = 1'b0;
   logic        ack_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (pv && !pab && !(bus_valid && bus_addr == pa && bus_we == pw)) r4_bad++;
         pv  = bus_valid && !bus_ready;
         pa  = bus_addr;
         pw  = bus_we;
         pab = abort_evt || !cfg_en;
         if (bus_valid && bus_ready && bus_we) wr_seen = 1'b1;
         if (periph_ack && !ack_prev) begin
            if (!wr_seen) r2_bad++;
            wr_seen = 1'b0;
         end
         ack_prev = periph_ack;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic fill_mem();
      for (int a = 0; a < 256; a++) begin
         if (a < 64 || (a >= 128 && a < 192)) begin
            tick();
            bd_we = 1'b1; bd_addr = 8'(a); bd_data = pat(a);
         end
      end
      tick();
      bd_we = 1'b0;
   endtask

   task automatic poke_word(input int a, input logic [31:0] v);
      for (int k = 0; k < 4; k++) begin
         tick();
         bd_we = 1'b1; bd_addr = 8'(a + k); bd_data = 8'(v >> (8 * k));
      end
      tick();
      bd_we = 1'b0;
   endtask

   task automatic clear_flags();
      tick(); flag_clr = 3'b111;
      tick(); flag_clr = 3'b000;
   endtask

   task automatic restart();
      tick(); cfg_en = 1'b0;
      tick(); cfg_en = 1'b1;
      tick();
   endtask

   task automatic serve(input string tag);
      int n;
      tick(); periph_req = 1'b1;
      n = 0;
      while (!periph_ack && n < 300) begin @(negedge clk); n++; end
      if (!periph_ack) chk({tag, " ack missing"}, 32'(periph_ack), 32'd1);
      tick(); periph_req = 1'b0;
      n = 0;
      @(negedge clk);
      while (periph_ack && n < 300) begin @(negedge clk); n++; end
      if (periph_ack) chk("R2 ack stuck", 32'(periph_ack), 32'd0);
   endtask

   task automatic expect_no_service(input string tag);
      int bad = 0;
      tick(); periph_req = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (periph_ack || bus_req) bad++;
      end
      chk(tag, 32'(bad), 32'd0);
      tick(); periph_req = 1'b0;
      tick();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = 8'h00;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 reset ack", 32'(periph_ack), 32'd0);
      chk("R1 reset busreq", 32'(bus_req), 32'd0);
      chk("R12 reset flags", 32'(flags), 32'd0);
      chk("R12 reset irq", 32'(irq), 32'd0);
      tick(); rst_n = 1'b1;

      // zero count and disabled channel: nothing happens
      cfg_irq_en = 3'b111; cfg_count = '0; cfg_paddr = 32'h10; cfg_maddr = 32'h90;
      restart();
      expect_no_service("R1 zero count");
      chk("R1 zero count flags", 32'(flags), 32'd0);
      tick(); cfg_en = 1'b0; cfg_count = 16'd3;
      expect_no_service("R1 disabled");

      // sweep: direction x sizes x increments, three items each
      for (int dir = 0; dir < 2; dir++)
      for (int ps = 0; ps < 3; ps++)
      for (int ms = 0; ms < 3; ms++)
      for (int pi = 0; pi < 2; pi++)
      for (int mi = 0; mi < 2; mi++) begin
         int sb; int db; int sbase; int dbase; int sinc; int dinc;
         tick();
         cfg_en = 1'b0; cfg_dir = 1'(dir); cfg_circ = 1'b0;
         cfg_psize = 2'(ps); cfg_msize = 2'(ms);
         cfg_pinc = 1'(pi); cfg_minc = 1'(mi); cfg_count = 16'd3;
         fill_mem();
         clear_flags();
         restart();
         for (int i = 0; i < 3; i++) serve("R2");
         sb    = nbytes(dir ? 2'(ms) : 2'(ps));
         db    = nbytes(dir ? 2'(ps) : 2'(ms));
         sbase = dir ? 32'h90 : 32'h10;
         dbase = dir ? 32'h10 : 32'h90;
         sinc  = dir ? mi : pi;
         dinc  = dir ? pi : mi;
         for (int i = 0; i < 3; i++) begin
            if (dinc != 0 || i == 2) begin
               logic [31:0] v;
               logic [31:0] m;
               v = pat_word(sbase + (sinc != 0 ? i * sb : 0), sb);
               m = (db == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * db)) - 32'd1);
               chk("R5 R6 R7 item data",
                   mem_word(dbase + (dinc != 0 ? i * db : 0), db), v & m);
            end
         end
         chk("R8 R9 flags after run", 32'(flags), 32'd3);
         chk("R12 irq", 32'(irq), 32'd1);
         clear_flags();
         @(negedge clk);
         chk("R12 cleared", 32'(flags), 32'd0);
      end
      expect_no_service("R8 stopped after count");

      // circular reload
      tick();
      cfg_en = 1'b0; cfg_dir = 1'b0; cfg_circ = 1'b1; cfg_psize = 2'd2; cfg_msize = 2'd2;
      cfg_pinc = 1'b1; cfg_minc = 1'b1; cfg_count = 16'd2;
      cfg_paddr = 32'h00; cfg_maddr = 32'h80;
      fill_mem(); clear_flags(); restart();
      serve("R10");
      @(negedge clk);
      chk("R9 half at one left", 32'(flags), 32'd1);
      serve("R10");
      chk("R10 first pass flags", 32'(flags), 32'd3);
      chk("R10 second word", mem_word(32'h84, 4), pat_word(32'h04, 4));
      clear_flags();
      poke_word(32'h00, 32'hDEAD_BEEF);
      serve("R10");
      chk("R10 reload dst", mem_word(32'h80, 4), 32'hDEAD_BEEF);
      chk("R10 flags again", 32'(flags), 32'd1);

      // disable and restart
      tick();
      cfg_en = 1'b0; cfg_circ = 1'b0; cfg_count = 16'd4;
      fill_mem(); clear_flags(); restart();
      serve("R13"); serve("R13");
      clear_flags();
      poke_word(32'h00, 32'h1234_5678);
      restart();
      serve("R13");
      chk("R13 restart at base", mem_word(32'h80, 4), 32'h1234_5678);
      chk("R13 full count", 32'(flags), 32'd0);
      serve("R13");
      chk("R13 half after two", 32'(flags), 32'd1);

      // grant delay
      tick();
      cfg_en = 1'b0; cfg_paddr = 32'h10; cfg_maddr = 32'h90;
      fill_mem(); clear_flags(); restart();
      tick(); other_busy = 1'b1; periph_req = 1'b1;
      repeat (8) @(negedge clk);
      chk("R3 waiting req", 32'(bus_req), 32'd1);
      chk("R3 no access", 32'(bus_valid), 32'd0);
      chk("R3 no ack", 32'(periph_ack), 32'd0);
      tick(); other_busy = 1'b0;
      begin
         int n = 0;
         while (!periph_ack && n < 100) begin @(negedge clk); n++; end
      end
      chk("R3 item after grant", mem_word(32'h90, 4), pat_word(32'h10, 4));
      chk("R3 bus released", 32'(bus_req), 32'd0);
      tick(); periph_req = 1'b0;
      tick(); tick();

      // abort while idle
      cfg_irq_en = 3'b100;
      clear_flags(); restart();
      serve("R11");
      tick(); abort_evt = 1'b1;
      tick(); abort_evt = 1'b0;
      @(negedge clk);
      chk("R11 abort flag", 32'(flags), 32'd4);
      chk("R12 abort irq", 32'(irq), 32'd1);
      expect_no_service("R11 halted");
      tick(); cfg_irq_en = 3'b000;
      @(negedge clk);
      chk("R12 masked irq", 32'(irq), 32'd0);
      chk("R12 flag kept", 32'(flags), 32'd4);

      // abort while waiting for grant
      cfg_irq_en = 3'b111;
      clear_flags(); restart();
      tick(); other_busy = 1'b1; periph_req = 1'b1;
      repeat (6) @(negedge clk);
      chk("R3 pending req", 32'(bus_req), 32'd1);
      tick(); abort_evt = 1'b1;
      tick(); abort_evt = 1'b0;
      @(negedge clk);
      chk("R11 req dropped", 32'(bus_req), 32'd0);
      chk("R11 flag mid", 32'(flags), 32'd4);
      tick(); other_busy = 1'b0;
      begin
         int bad = 0;
         for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (periph_ack || bus_req) bad++;
         end
         chk("R11 no service after abort", 32'(bad), 32'd0);
      end
      tick(); periph_req = 1'b0;
      tick();

      chk("R4 access stability", 32'(r4_bad), 32'd0);
      chk("R2 ack after write", 32'(r2_bad), 32'd0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule